// File: doc/BRIEF.md
# Command-Driven Pointer FIFO with Occupancy Adder

This block is a 128-word by 16-bit queue whose write and read positions are two free-standing counters. An external sequencer moves them with discrete commands: hold a counter at zero, or step it by one. A write command stores the input word at the current write position and steps the write counter on the same clock edge. The read side always shows the word at the current read position, and a separate step command moves to the next word. Software therefore reads a word first and steps afterwards.

Occupancy is not tracked by a separate count. It is the output of an 8-bit adder that forms write + (inverted read) + 1 over the full 8-bit counters. The adder's sign, overflow and carry bits and the two counters' upper bits are all visible for diagnostics. Two direction flags record which counter last caught up with the other. This tells a full queue apart from an empty one when the 7-bit positions are equal.

Everything is read through one register read port. A select input picks the word. While the read strobe is high, the occupancy byte comes from a frozen snapshot, so a write that lands mid-read cannot tear the value.

Top module: `cpf_fifo`

## Requirements
- R1: After synchronous reset both counters are 0, both direction flags are 0 and `not_empty` is 0. Select 1 reads 0x0000 and select 2 reads 0x2000, because the carry is set when the counters are equal.
- R2: When `wr_cmd` is high and `wr_ptr_clr` is low, the edge stores `wr_data` at the low 7 bits of the write counter and steps the write counter by one. When `wr_ptr_clr` is high, nothing is stored.
- R3: Select 0 reads, without delay, the stored word at the low 7 bits of the read counter. When `rd_inc` is high and `rd_ptr_clr` is low, the edge steps the read counter by one.
- R4: At every edge where a clear input is high, its counter becomes 0, whatever step or write command is present.
- R5: Select 1 reads the read position in bits 6:0 and the write position in bits 14:8. Bits 7 and 15 read 0.
- R6: Select 2 reads an adder result. Bits 6:0 are (W−R) mod 128 and bits 10:7 are 0. Bit 11 is bit 7 of (W−R) mod 256. Bit 12 is signed overflow of the 8-bit subtraction. Bit 13 is the carry out, set when W ≥ R. Bit 14 is bit 7 of R and bit 15 is bit 7 of W, where W and R are the 8-bit counters.
- R7: `not_empty` is 1 exactly when the low 7 bits of the two counters differ.
- R8: Select 3 reads the write-leads flag in bit 0 and the read-leads flag in bit 1. All other bits are 0. At most one flag is set at a time. An edge with both clears high sets write-leads. An edge where the positions are equal and only the write counter steps sets write-leads. An edge where the positions are equal and only the read counter steps sets read-leads. Setting one flag clears the other.
- R9: When both counters step on the same edge, both advance and neither flag changes.
- R10: At every edge where `bus_rd` is high, the occupancy snapshot keeps its value. While `bus_rd` is high, bits 7:0 of select 2 show the snapshot. The snapshot equals the live occupancy whenever `bus_rd` was low at the previous edge.
- R11: Both counters are 8 bits wide and wrap from 255 to 0. The 256th step from 0 returns a counter to 0 with its upper bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_ptr_clr | input | 1 | Hold the write counter at zero |
| rd_ptr_clr | input | 1 | Hold the read counter at zero |
| wr_cmd | input | 1 | Store `wr_data` and step the write counter |
| wr_data | input | 16 | Word to store |
| rd_inc | input | 1 | Step the read counter |
| bus_rd | input | 1 | Read strobe; freezes the occupancy byte |
| bus_sel | input | 2 | Word select: 0 data, 1 positions, 2 difference, 3 flags |
| bus_rdata | output | 16 | Selected read word |
| not_empty | output | 1 | Positions differ |

## Verification
Counter, flag and snapshot effects are due one edge after the command that causes them. The data, position, difference and flag words are combinational views of that registered state, so they are valid in the same cycle once the edge has passed. The bench drives each command half a period before an edge and applies it to its reference model at that edge. It then samples all four select values at the following falling edge, which is exactly one register stage later. Stored data is due on the read word one edge after the write, and only when the read position points at it. The snapshot comparison uses the strobe level in force during the sampled cycle.

// File: rtl/cpf_pkg.sv
package cpf_pkg;

    localparam int ADDR_W = 7;
    localparam int CNT_W  = ADDR_W + 1;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WORD_W = 16;
    localparam int SEL_W  = 2;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA  = 2'd0,
        SEL_PTRS  = 2'd1,
        SEL_DIFF  = 2'd2,
        SEL_FLAGS = 2'd3
    } bus_sel_e;

    typedef struct packed {
        logic  wr_top;
        logic  rd_top;
        logic  carry;
        logic  ovf;
        logic  sign;
        addr_t occ;
    } diff_t;

    // write + inverted read + 1 over the full counter width
    function automatic diff_t form_diff(input cnt_t w, input cnt_t r);
        diff_t          d;
        cnt_t           rinv;
        logic [CNT_W:0] sum;
        rinv     = ~r;
        sum      = {1'b0, w} + {1'b0, rinv} + {{CNT_W{1'b0}}, 1'b1};
        d.wr_top = w[CNT_W-1];
        d.rd_top = r[CNT_W-1];
        d.carry  = sum[CNT_W];
        d.sign   = sum[CNT_W-1];
        d.ovf    = (w[CNT_W-1] == rinv[CNT_W-1]) && (sum[CNT_W-1] != w[CNT_W-1]);
        d.occ    = sum[ADDR_W-1:0];
        return d;
    endfunction

    function automatic word_t pack_ptrs(input cnt_t w, input cnt_t r);
        return {1'b0, w[ADDR_W-1:0], 1'b0, r[ADDR_W-1:0]};
    endfunction

endpackage

// File: rtl/cpf_ptr_cnt.sv
module cpf_ptr_cnt
    import cpf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output cnt_t cnt_q,
    output cnt_t cnt_nxt,
    output logic step
);

    assign step = inc && !clr;

    always_comb begin
        if (clr)
            cnt_nxt = '0;
        else if (step)
            cnt_nxt = cnt_q + 1'b1;
        else
            cnt_nxt = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nxt;
    end

endmodule

// File: rtl/cpf_store.sv
module cpf_store
    import cpf_pkg::*;
(
    input  logic  clk,
    input  logic  we,
    input  addr_t waddr,
    input  word_t wdata,
    input  addr_t raddr,
    output word_t rdata
);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/cpf_lap.sv
module cpf_lap (
    input  logic clk,
    input  logic rst,
    input  logic both_clr,
    input  logic pos_eq,
    input  logic wr_step,
    input  logic rd_step,
    output logic wlead,
    output logic rlead
);

    logic set_w, set_r;

    assign set_w = both_clr || (pos_eq && wr_step && !rd_step);
    assign set_r = !both_clr && pos_eq && rd_step && !wr_step;

    always_ff @(posedge clk) begin
        if (rst) begin
            wlead <= 1'b0;
            rlead <= 1'b0;
        end else if (set_w) begin
            wlead <= 1'b1;
            rlead <= 1'b0;
        end else if (set_r) begin
            wlead <= 1'b0;
            rlead <= 1'b1;
        end
    end

endmodule

// File: rtl/cpf_diff.sv
module cpf_diff
    import cpf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hold,
    input  cnt_t  w_q,
    input  cnt_t  r_q,
    input  cnt_t  w_nxt,
    input  cnt_t  r_nxt,
    output word_t word,
    output addr_t snap_occ
);

    diff_t live;
    diff_t ahead;
    addr_t occ_out;

    assign live  = form_diff(w_q, r_q);
    assign ahead = form_diff(w_nxt, r_nxt);

    // snapshot tracks next-cycle occupancy until the strobe is seen
    always_ff @(posedge clk) begin
        if (rst)
            snap_occ <= '0;
        else if (!hold)
            snap_occ <= ahead.occ;
    end

    assign occ_out = hold ? snap_occ : live.occ;

    assign word = {live.wr_top, live.rd_top, live.carry, live.ovf, live.sign,
                   {(WORD_W-ADDR_W-5){1'b0}}, occ_out};

endmodule

// File: rtl/cpf_fifo.sv
module cpf_fifo
    import cpf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ptr_clr,
    input  logic              rd_ptr_clr,
    input  logic              wr_cmd,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_inc,
    input  logic              bus_rd,
    input  logic [SEL_W-1:0]  bus_sel,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              not_empty
);

    localparam int NPTR = 2;
    localparam int WI   = 0;
    localparam int RI   = 1;

    logic clr_v  [NPTR];
    logic inc_v  [NPTR];
    logic step_v [NPTR];
    cnt_t cur_v  [NPTR];
    cnt_t nxt_v  [NPTR];

    assign clr_v[WI] = wr_ptr_clr;
    assign clr_v[RI] = rd_ptr_clr;
    assign inc_v[WI] = wr_cmd;
    assign inc_v[RI] = rd_inc;

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        cpf_ptr_cnt u_cnt (
            .clk     (clk),
            .rst     (rst),
            .clr     (clr_v[g]),
            .inc     (inc_v[g]),
            .cnt_q   (cur_v[g]),
            .cnt_nxt (nxt_v[g]),
            .step    (step_v[g])
        );
    end

    cnt_t  wp_q, rp_q;
    logic  pos_eq;
    logic  wlead, rlead;
    word_t rd_word, diff_word;
    addr_t snap_occ;

    assign wp_q   = cur_v[WI];
    assign rp_q   = cur_v[RI];
    assign pos_eq = (wp_q[ADDR_W-1:0] == rp_q[ADDR_W-1:0]);

    cpf_store u_store (
        .clk   (clk),
        .we    (step_v[WI]),
        .waddr (wp_q[ADDR_W-1:0]),
        .wdata (wr_data),
        .raddr (rp_q[ADDR_W-1:0]),
        .rdata (rd_word)
    );

    cpf_lap u_lap (
        .clk      (clk),
        .rst      (rst),
        .both_clr (wr_ptr_clr && rd_ptr_clr),
        .pos_eq   (pos_eq),
        .wr_step  (step_v[WI]),
        .rd_step  (step_v[RI]),
        .wlead    (wlead),
        .rlead    (rlead)
    );

    cpf_diff u_diff (
        .clk      (clk),
        .rst      (rst),
        .hold     (bus_rd),
        .w_q      (wp_q),
        .r_q      (rp_q),
        .w_nxt    (nxt_v[WI]),
        .r_nxt    (nxt_v[RI]),
        .word     (diff_word),
        .snap_occ (snap_occ)
    );

    assign not_empty = !pos_eq;

    always_comb begin
        unique case (bus_sel_e'(bus_sel))
            SEL_DATA:  bus_rdata = rd_word;
            SEL_PTRS:  bus_rdata = pack_ptrs(wp_q, rp_q);
            SEL_DIFF:  bus_rdata = diff_word;
            SEL_FLAGS: bus_rdata = {{(WORD_W-2){1'b0}}, rlead, wlead};
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cpf_fifo_chk.sv
module cpf_fifo_chk
    import cpf_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  wr_ptr_clr,
    input logic  rd_ptr_clr,
    input logic  wr_cmd,
    input logic  rd_inc,
    input logic  bus_rd,
    input logic  not_empty,
    input cnt_t  wp_q,
    input cnt_t  rp_q,
    input logic  wlead,
    input logic  rlead,
    input addr_t snap_occ
);

    // R4
    wr_clr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ptr_clr |=> (wp_q == '0));

    // R4
    rd_clr_chk: assert property (@(posedge clk) disable iff (rst)
        rd_ptr_clr |=> (rp_q == '0));

    // R2
    wr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && !wr_ptr_clr) |=> (wp_q == cnt_t'($past(wp_q) + 1'b1)));

    // R3
    rd_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_inc && !rd_ptr_clr) |=> (rp_q == cnt_t'($past(rp_q) + 1'b1)));

    // R8
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wlead, rlead}));

    // R8
    both_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr_clr && rd_ptr_clr) |=> (wlead && !rlead && !not_empty));

    // R9
    dual_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && rd_inc && !wr_ptr_clr && !rd_ptr_clr) |=> ($stable(wlead) && $stable(rlead)));

    // R10
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> $stable(snap_occ));

endmodule

bind cpf_fifo cpf_fifo_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_ptr_clr (wr_ptr_clr),
    .rd_ptr_clr (rd_ptr_clr),
    .wr_cmd     (wr_cmd),
    .rd_inc     (rd_inc),
    .bus_rd     (bus_rd),
    .not_empty  (not_empty),
    .wp_q       (wp_q),
    .rp_q       (rp_q),
    .wlead      (wlead),
    .rlead      (rlead),
    .snap_occ   (snap_occ)
);

// File: tb/tb_cpf_fifo.sv
module tb_cpf_fifo;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_ptr_clr = 1'b0, rd_ptr_clr = 1'b0;
    logic        wr_cmd = 1'b0, rd_inc = 1'b0, bus_rd = 1'b0;
    logic [15:0] wr_data = '0;
    logic [1:0]  bus_sel = '0;
    logic [15:0] bus_rdata;
    logic        not_empty;

    always #10 clk = ~clk;

    cpf_fifo dut (
        .clk(clk), .rst(rst), .wr_ptr_clr(wr_ptr_clr), .rd_ptr_clr(rd_ptr_clr),
        .wr_cmd(wr_cmd), .wr_data(wr_data), .rd_inc(rd_inc), .bus_rd(bus_rd),
        .bus_sel(bus_sel), .bus_rdata(bus_rdata), .not_empty(not_empty)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    // reference model
    int          m_w, m_r, m_snap;
    bit          m_wl, m_rl;
    logic [15:0] m_mem [128];
    bit          m_val [128];

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int occ_of(input int w, input int r);
        return ((w - r) % 128 + 128) % 128;
    endfunction

    function automatic logic [15:0] exp_diff(input int w, input int r, input int low);
        logic [15:0] e;
        int d8, sw, sr, sd;
        d8 = ((w - r) % 256 + 256) % 256;
        sw = (w > 127) ? w - 256 : w;
        sr = (r > 127) ? r - 256 : r;
        sd = sw - sr;
        e       = '0;
        e[6:0]  = low[6:0];
        e[11]   = d8 >= 128;
        e[12]   = (sd > 127) || (sd < -128);
        e[13]   = w >= r;
        e[14]   = r >= 128;
        e[15]   = w >= 128;
        return e;
    endfunction

    task automatic model_reset();
        m_w = 0; m_r = 0; m_snap = 0; m_wl = 0; m_rl = 0;
        for (int i = 0; i < 128; i++) m_val[i] = 0;
    endtask

    task automatic model_edge();
        bit ws, rs, eq;
        ws = wr_cmd && !wr_ptr_clr;
        rs = rd_inc && !rd_ptr_clr;
        eq = (m_w % 128) == (m_r % 128);
        if (wr_ptr_clr && rd_ptr_clr) begin m_wl = 1; m_rl = 0; end
        else if (eq && ws && !rs)     begin m_wl = 1; m_rl = 0; end
        else if (eq && rs && !ws)     begin m_wl = 0; m_rl = 1; end
        if (ws) begin m_mem[m_w % 128] = wr_data; m_val[m_w % 128] = 1; end
        if (wr_ptr_clr) m_w = 0; else if (ws) m_w = (m_w + 1) % 256;
        if (rd_ptr_clr) m_r = 0; else if (rs) m_r = (m_r + 1) % 256;
        if (!bus_rd) m_snap = occ_of(m_w, m_r);
    endtask

    task automatic read_sel(input int s, output logic [15:0] v);
        bus_sel = s[1:0];
        #1;
        v = bus_rdata;
    endtask

    task automatic compare_all();
        logic [15:0] v;
        logic [15:0] pexp;
        read_sel(0, v);
        if (m_val[m_r % 128]) chk("R3 read word", v, m_mem[m_r % 128]);
        read_sel(1, v);
        pexp = {1'b0, 7'(m_w % 128), 1'b0, 7'(m_r % 128)};
        chk("R5 position word", v, pexp);
        read_sel(2, v);
        chk("R6 difference word", v, exp_diff(m_w, m_r, bus_rd ? m_snap : occ_of(m_w, m_r)));
        read_sel(3, v);
        chk("R8 flag word", v, {14'b0, m_rl, m_wl});
        chk("R7 not_empty", {15'b0, not_empty}, {15'b0, (m_w % 128) != (m_r % 128)});
    endtask

    task automatic step(input logic wc, input logic [15:0] wd, input logic ri,
                        input logic wclr, input logic rclr, input logic brd);
        wr_cmd = wc; wr_data = wd; rd_inc = ri;
        wr_ptr_clr = wclr; rd_ptr_clr = rclr; bus_rd = brd;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, held;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // reset state
        read_sel(1, v); chk("R1 positions after reset", v, 16'h0000);
        read_sel(2, v); chk("R1 difference after reset", v, 16'h2000);
        read_sel(3, v); chk("R1 flags after reset", v, 16'h0000);
        chk("R1 not_empty after reset", {15'b0, not_empty}, 16'h0000);

        // five writes from empty: first sets write-leads
        for (int i = 0; i < 5; i++) step(1, 16'hA100 + 16'(i), 0, 0, 0, 0);
        read_sel(1, v); chk("R2 write position after 5 writes", v, 16'h0500);
        read_sel(3, v); chk("R8 write-leads after first write", v, 16'h0001);

        // read-then-step three times
        for (int i = 0; i < 3; i++) begin
            read_sel(0, v); chk("R3 word before step", v, 16'hA100 + 16'(i));
            step(0, 0, 1, 0, 0, 0);
        end

        // simultaneous write and step
        for (int i = 0; i < 3; i++) step(1, 16'hB200 + 16'(i), 1, 0, 0, 0);
        read_sel(2, v); chk("R9 occupancy unchanged by dual steps", {9'b0, v[6:0]}, 16'h0002);
        read_sel(3, v); chk("R9 flags unchanged by dual steps", v, 16'h0001);

        // drain, then one extra read step at equal positions
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        read_sel(3, v); chk("R8 read-leads after catch-up", v, 16'h0002);
        read_sel(2, v); chk("R6 occupancy 127 when read passes write", {9'b0, v[6:0]}, 16'h007F);
        step(1, 16'hC300, 0, 0, 0, 0);
        step(1, 16'hC301, 0, 0, 0, 0);
        read_sel(3, v); chk("R8 write-leads after write at equal", v, 16'h0001);

        // held clears override commands
        for (int i = 0; i < 3; i++) step(1, 16'hDEAD, 1, 1, 1, 0);
        read_sel(1, v); chk("R4 positions held at zero", v, 16'h0000);
        chk("R4 not_empty during clear", {15'b0, not_empty}, 16'h0000);

        // snapshot hold across writes
        step(1, 16'h1111, 0, 0, 0, 0);
        step(1, 16'h2222, 0, 0, 0, 1);
        read_sel(2, v); held = v;
        chk("R10 snapshot equals occupancy at strobe start", {8'b0, held[7:0]}, 16'h0001);
        step(1, 16'h3333, 0, 0, 0, 1);
        step(1, 16'h4444, 0, 0, 0, 1);
        read_sel(2, v); chk("R10 low byte frozen during read", {8'b0, v[7:0]}, {8'b0, held[7:0]});
        step(0, 0, 0, 0, 0, 0);
        read_sel(2, v); chk("R10 low byte live after release", {8'b0, v[7:0]}, 16'h0004);

        // wrap of the 8-bit write counter
        step(0, 0, 0, 1, 1, 0);
        for (int i = 0; i < 130; i++) step(1, 16'(i * 7 + 3), 0, 0, 0, 0);
        read_sel(2, v); chk("R11 write upper bit set at 130", {15'b0, v[15]}, 16'h0001);
        for (int i = 0; i < 126; i++) step(1, 16'(i * 5 + 1), 0, 0, 0, 0);
        read_sel(1, v); chk("R11 write counter wrapped to 0", v, 16'h0000);
        read_sel(2, v); chk("R11 upper bit clear after wrap", v, 16'h2000);

        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int rv;
            rv = int'($urandom_range(0, 99));
            step(rv < 50, 16'($urandom), (rv % 3) == 0, rv == 97, rv == 98 || rv == 96,
                 ((i / 5) % 3) == 1);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule